// File: doc/BRIEF.md
# PWM-Synchronised A/D Conversion Scheduler

This block sequences an external analog-to-digital converter from the PWM timing. Each rising edge of the PWM synchronisation pulse starts one sequence of two conversions. The first always samples the motor current-feedback input. The second samples one of six auxiliary analog inputs. The auxiliary input changes on every sequence, so each auxiliary input is refreshed once in every six sync events, while current feedback is refreshed on every event.

The block drives the converter's channel select and a one-cycle start pulse. It waits for the converter's done strobe and stores the accompanying 12-bit sample in a result register for that channel. Each channel also has a fresh flag. The flag is set when the register takes a new sample and is cleared when the channel is read. A one-cycle strobe marks the end of each sequence. A sync edge that arrives while a sequence is still running is ignored and counted in a saturating overrun counter.

Top module: `adc_sync_sched`

## Requirements
- R1: After reset, start, sequence-done and the overrun count are all zero. The auxiliary pointer is 1. Every result register reads 0 and every fresh flag reads 0.
- R2: A rising edge on `pwm_sync_i` seen while idle makes `adc_start_o` high for exactly one cycle, starting in the cycle after the edge is sampled, with `adc_chan_o` = 0. Channel code 0 is current feedback.
- R3: The first `adc_done_i` after the current-feedback start is followed by a second one-cycle start, with `adc_chan_o` equal to the auxiliary pointer. Auxiliary inputs use channel codes 1 to 6.
- R4: The auxiliary pointer starts at 1. It advances by one after each auxiliary result is stored, and it wraps from 6 back to 1.
- R5: On a done strobe in a waiting state, `adc_data_i` is stored in the register of the channel being converted. Reading that channel through `rd_chan_i` then returns the stored value. Channel code 7 always reads 0.
- R6: A channel's fresh flag is set when its register is written. It is cleared on the clock edge where `rd_en_i` is high with that channel selected. A channel that has not been written since its last read reports 0.
- R7: `seq_done_o` is high for exactly one cycle per sequence, in the cycle after the auxiliary result is written.
- R8: A sync rising edge seen while a sequence is running starts no conversion and does not restart the sequence. It increments `ovr_count_o`, which saturates at its maximum value.
- R9: A done strobe that arrives while no conversion is pending changes no result register and no fresh flag, and it causes no start or sequence-done pulse.
- R10: Holding `pwm_sync_i` high for many cycles triggers exactly one sequence. Only the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_sync_i | input | 1 | PWM synchronisation pulse |
| adc_chan_o | output | CH_W (3) | Converter channel select (0 = current, 1..6 = auxiliary) |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_done_i | input | 1 | Conversion-done strobe |
| adc_data_i | input | DW (12) | Sample that accompanies the done strobe |
| rd_en_i | input | 1 | Read strobe; clears the selected channel's fresh flag |
| rd_chan_i | input | CH_W (3) | Channel to read |
| rd_data_o | output | DW (12) | Result register of the selected channel |
| rd_fresh_o | output | 1 | Fresh flag of the selected channel |
| seq_done_o | output | 1 | One-cycle end-of-sequence strobe |
| ovr_count_o | output | OVR_W (8) | Saturating count of ignored sync edges |

## Verification
The hardest situation to reach from the ports is a sync rising edge that lands while a sequence is still in flight. The sync input must fall and rise again inside the converter's latency window. The bench does this by briefly dropping and re-raising sync during the current-feedback wait. It checks that exactly two starts and one sequence-done pulse occur, and that the overrun count steps up. A narrow counter width is used so that saturation is also reached. The pointer wrap is covered by running well over twelve back-to-back sequences and comparing every stored sample with values computed from the event number.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CUR_GO   = 3'd1,
    ST_CUR_WAIT = 3'd2,
    ST_AUX_GO   = 3'd3,
    ST_AUX_WAIT = 3'd4,
    ST_FIN      = 3'd5
  } seq_state_t;
endpackage

// File: rtl/adc_sched_rotor.sv
module adc_sched_rotor #(
  parameter int NUM_AUX = 6,
  parameter int CH_W    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [CH_W-1:0] ptr_o
);
  localparam logic [CH_W-1:0] PTR_FIRST = CH_W'(1);
  localparam logic [CH_W-1:0] PTR_LAST  = CH_W'(NUM_AUX);

  logic [CH_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) begin
      if (ptr_q == PTR_LAST) ptr_d = PTR_FIRST;
      else                   ptr_d = ptr_q + CH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= PTR_FIRST;
    else if (adv_i) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q >= PTR_FIRST) && (ptr_q <= PTR_LAST)); // R4
  AST_PTR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (ptr_q != $past(ptr_q))); // R4
endmodule

// File: rtl/adc_sched_fsm.sv
module adc_sched_fsm
  import adc_sched_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [CH_W-1:0]  aux_ptr_i,
  input  logic             adc_done_i,
  output logic             adc_start_o,
  output logic [CH_W-1:0]  adc_chan_o,
  output logic             cur_wr_o,
  output logic             aux_wr_o,
  output logic             aux_adv_o,
  output logic             seq_done_o,
  output logic [OVR_W-1:0] ovr_cnt_o
);
  localparam logic [OVR_W-1:0] OVR_MAX = {OVR_W{1'b1}};

  seq_state_t       state_q, state_d;
  logic             sync_q;
  logic             sync_rise;
  logic [OVR_W-1:0] ovr_q, ovr_d;
  logic             ovr_en;

  assign sync_rise = sync_i & ~sync_q;

  always_comb begin
    state_d   = state_q;
    cur_wr_o  = 1'b0;
    aux_wr_o  = 1'b0;
    aux_adv_o = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (sync_rise) state_d = ST_CUR_GO;
      ST_CUR_GO:   state_d = ST_CUR_WAIT;
      ST_CUR_WAIT: if (adc_done_i) begin
                     cur_wr_o = 1'b1;
                     state_d  = ST_AUX_GO;
                   end
      ST_AUX_GO:   state_d = ST_AUX_WAIT;
      ST_AUX_WAIT: if (adc_done_i) begin
                     aux_wr_o  = 1'b1;
                     aux_adv_o = 1'b1;
                     state_d   = ST_FIN;
                   end
      ST_FIN:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ovr_en = sync_rise && (state_q != ST_IDLE) && (ovr_q != OVR_MAX);
    ovr_d  = ovr_q + OVR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sync_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_q  <= sync_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= '0;
    else if (ovr_en) ovr_q <= ovr_d;
  end

  assign adc_start_o = (state_q == ST_CUR_GO) || (state_q == ST_AUX_GO);
  assign adc_chan_o  = ((state_q == ST_AUX_GO) || (state_q == ST_AUX_WAIT)) ? aux_ptr_i : '0;
  assign seq_done_o  = (state_q == ST_FIN);
  assign ovr_cnt_o   = ovr_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o); // R2
  AST_IDLE_RISE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sync_rise) |=> (adc_start_o && adc_chan_o == '0)); // R2
  AST_SEQ_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |=> !seq_done_o); // R7
  AST_DONE_AFTER_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr_o |=> seq_done_o); // R7
  AST_OVR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ovr_q >= $past(ovr_q))); // R8
endmodule

// File: rtl/adc_sched_bank.sv
module adc_sched_bank #(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3,
  parameter int DW     = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_en_i,
  input  logic [CH_W-1:0] rd_ch_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_fresh_o
);
  logic [DW-1:0]     data_q [NUM_CH];
  logic [NUM_CH-1:0] fresh_q;
  logic [NUM_CH-1:0] hit_wr, hit_rd;
  logic              rd_valid;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic fresh_d;
    assign hit_wr[g] = wr_en_i && (wr_ch_i == CH_W'(g));
    assign hit_rd[g] = rd_en_i && (rd_ch_i == CH_W'(g));

    always_comb begin
      fresh_d = fresh_q[g];
      if (hit_wr[g])      fresh_d = 1'b1;
      else if (hit_rd[g]) fresh_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q[g] <= '0;
      else if (hit_wr[g]) data_q[g] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fresh_q[g] <= 1'b0;
      else        fresh_q[g] <= fresh_d;
    end
  end

  always_comb begin
    rd_data_o  = '0;
    rd_fresh_o = 1'b0;
    rd_valid   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch_i == CH_W'(i)) begin
        rd_data_o  = data_q[i];
        rd_fresh_o = fresh_q[i];
        rd_valid   = 1'b1;
      end
    end
  end

  AST_FRESH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> fresh_q[$past(wr_ch_i)]); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_valid && !(wr_en_i && wr_ch_i == rd_ch_i)) |=> !fresh_q[$past(rd_ch_i)]); // R6
endmodule

// File: rtl/adc_sync_sched.sv
module adc_sync_sched #(
  parameter int NUM_AUX = 6,
  parameter int DW      = 12,
  parameter int OVR_W   = 8,
  localparam int NUM_CH = NUM_AUX + 1,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_sync_i,
  output logic [CH_W-1:0]  adc_chan_o,
  output logic             adc_start_o,
  input  logic             adc_done_i,
  input  logic [DW-1:0]    adc_data_i,
  input  logic             rd_en_i,
  input  logic [CH_W-1:0]  rd_chan_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_fresh_o,
  output logic             seq_done_o,
  output logic [OVR_W-1:0] ovr_count_o
);
  logic [CH_W-1:0] aux_ptr;
  logic            cur_wr, aux_wr, aux_adv;
  logic            wr_en;
  logic [CH_W-1:0] wr_ch;

  adc_sched_rotor #(.NUM_AUX(NUM_AUX), .CH_W(CH_W)) u_rotor (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (aux_adv),
    .ptr_o (aux_ptr)
  );

  adc_sched_fsm #(.CH_W(CH_W), .OVR_W(OVR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (pwm_sync_i),
    .aux_ptr_i   (aux_ptr),
    .adc_done_i  (adc_done_i),
    .adc_start_o (adc_start_o),
    .adc_chan_o  (adc_chan_o),
    .cur_wr_o    (cur_wr),
    .aux_wr_o    (aux_wr),
    .aux_adv_o   (aux_adv),
    .seq_done_o  (seq_done_o),
    .ovr_cnt_o   (ovr_count_o)
  );

  assign wr_en = cur_wr | aux_wr;
  assign wr_ch = aux_wr ? aux_ptr : '0;

  adc_sched_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DW(DW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en),
    .wr_ch_i    (wr_ch),
    .wr_data_i  (adc_data_i),
    .rd_en_i    (rd_en_i),
    .rd_ch_i    (rd_chan_i),
    .rd_data_o  (rd_data_o),
    .rd_fresh_o (rd_fresh_o)
  );

  AST_START_ONLY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start_o && adc_chan_o != '0) |-> (adc_chan_o == aux_ptr)); // R3
endmodule

// File: tb/adc_sync_sched_test.sv
module adc_sync_sched_test;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [2:0]  chan;
  logic        start;
  logic        done_w;
  logic [11:0] data_w;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_chan = 3'd0;
  logic [11:0] rd_data;
  logic        rd_fresh;
  logic        seq_done;
  logic [1:0]  ovr;

  logic        stub_done = 1'b0;
  logic [11:0] stub_data = '0;
  logic        force_done = 1'b0;
  logic [11:0] force_data = '0;
  int          stub_cnt = 0;
  logic        stub_busy = 1'b0;
  logic [2:0]  stub_ch = '0;
  logic [8:0]  stub_seq = '0;
  logic [2:0]  ch_prev = '0, ch_last = '0;
  int          starts = 0;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  assign done_w = stub_done | force_done;
  assign data_w = force_done ? force_data : stub_data;

  adc_sync_sched #(.NUM_AUX(6), .DW(12), .OVR_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_sync_i(sync),
    .adc_chan_o(chan), .adc_start_o(start),
    .adc_done_i(done_w), .adc_data_i(data_w),
    .rd_en_i(rd_en), .rd_chan_i(rd_chan),
    .rd_data_o(rd_data), .rd_fresh_o(rd_fresh),
    .seq_done_o(seq_done), .ovr_count_o(ovr)
  );

  // Behavioural converter: done LAT cycles after start, data = {channel, conversion index}
  always @(posedge clk) begin
    stub_done <= 1'b0;
    if (start) begin
      stub_busy <= 1'b1;
      stub_cnt  <= LAT;
      stub_ch   <= chan;
      ch_prev   <= ch_last;
      ch_last   <= chan;
      starts    <= starts + 1;
    end else if (stub_busy) begin
      if (stub_cnt == 1) begin
        stub_busy <= 1'b0;
        stub_done <= 1'b1;
        stub_data <= {stub_ch, stub_seq};
        stub_seq  <= stub_seq + 9'd1;
      end
      stub_cnt <= stub_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int ch, output logic [11:0] d, output bit f, output bit fa);
    @(negedge clk);
    rd_chan = 3'(ch);
    rd_en = 1'b0;
    #1;
    d = rd_data;
    f = rd_fresh;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    fa = rd_fresh;
  endtask

  int ev = 0;
  int exp_ovr = 0;

  task automatic run_event(input bit add_ovr);
    int dn;
    int st0;
    int aux;
    logic [11:0] d;
    bit f, fa;
    dn = 0;
    st0 = starts;
    aux = (ev % 6) + 1;
    @(negedge clk);
    sync = 1'b1;
    @(negedge clk);
    chk(start == 1'b1 && chan == 3'd0, "R2", {start, chan}, 4'h8);
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (seq_done) dn++;
      if (add_ovr && c == 0) sync = 1'b0;
      if (add_ovr && c == 1) sync = 1'b1;
      if (c == 28) sync = 1'b0;
    end
    if (add_ovr && exp_ovr < 3) exp_ovr++;
    chk(dn == 1, "R7 R10 one seq_done", dn, 1);
    chk(starts - st0 == 2, "R8 R10 two starts", starts - st0, 2);
    chk(ch_prev == 3'd0 && ch_last == 3'(aux), "R3 R4 channel order", {ch_prev, ch_last}, aux);
    chk(ovr == 2'(exp_ovr), "R8 overrun count", ovr, exp_ovr);
    rd(0, d, f, fa);
    chk(d == {3'd0, 9'(2*ev)}, "R5 current result", d, {3'd0, 9'(2*ev)});
    chk(f == 1'b1 && fa == 1'b0, "R6 current fresh set/clear", {f, fa}, 2);
    rd(aux, d, f, fa);
    chk(d == {3'(aux), 9'(2*ev+1)}, "R5 aux result", d, {3'(aux), 9'(2*ev+1)});
    chk(f == 1'b1 && fa == 1'b0, "R6 aux fresh set/clear", {f, fa}, 2);
    if (ev > 0) begin
      rd(((ev + 5) % 6) + 1, d, f, fa);
      chk(f == 1'b0, "R6 unwritten channel stale", f, 0);
    end
    ev++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] d;
    bit f, fa;
    int st0;
    int dn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start == 1'b0 && seq_done == 1'b0 && ovr == 2'd0, "R1 outputs idle", {start, seq_done, ovr}, 0);
    for (int ch = 0; ch < 8; ch++) begin
      rd_chan = 3'(ch);
      #1;
      chk(rd_data == 12'd0 && rd_fresh == 1'b0, "R1 register reset", {rd_data, rd_fresh}, 0);
      @(negedge clk);
    end

    // R4 rotation over two full wraps
    for (int k = 0; k < 14; k++) run_event(1'b0);

    // R9 done strobe with nothing pending
    st0 = starts;
    dn = 0;
    @(negedge clk);
    force_data = 12'hABC;
    force_done = 1'b1;
    @(negedge clk);
    force_done = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (seq_done) dn++;
    end
    chk(starts == st0 && dn == 0, "R9 no start or done", starts - st0 + dn, 0);
    rd(0, d, f, fa);
    chk(d == {3'd0, 9'(2*(ev-1))} && f == 1'b0, "R9 register unchanged", d, {3'd0, 9'(2*(ev-1))});

    // R8 overruns, saturating at 3 with a 2-bit counter
    for (int k = 0; k < 4; k++) run_event(1'b1);

    // R5 unused channel code
    @(negedge clk);
    rd_chan = 3'd7;
    #1;
    chk(rd_data == 12'd0 && rd_fresh == 1'b0, "R5 code 7 reads zero", rd_data, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule